// File: doc/BRIEF.md
# Unlock Command Sequence Decoder

This block sits beside a byte-wide non-volatile store and watches every bus write. Each write is an address and a data byte. The block compares the stream of writes against fixed unlock command sequences. Each sequence opens with a two-write prefix: AAh written to 5555h, then 55h written to 2AAAh. The sequences control four things: a write-protect mode, a request to erase the whole chip, a product-identification read mode, and whether a write may reach the page loader.

The protect flag has no reset. At power-up it starts set, and a reset leaves it as it is, so protection behaves as if it were kept through a power cycle. The identification mode is cleared by reset. When the protect flag is set, a data write reaches the page loader only inside a window. The enable sequence opens that window. The window stays open while writes keep arriving, and it closes after a run of idle cycles. In identification mode, reads at addresses 0 and 1 return the two identification codes.

Top module: `unlock_seq_decoder`

## Requirements
- R1: Sequence addresses are matched on address bits 14..0 only. Bit 15 has no effect on matching.
- R2: The writes AAh@5555h, 55h@2AAAh, A0h@5555h set protect_on and open the load window. The last write of this sequence is never forwarded.
- R3: While protect_on is 1, a write is forwarded only while the window is open. Forwarding means pl_write_ok pulses in the next cycle, and pl_addr/pl_data carry that write. Each write restarts the idle count. The window closes after WINDOW_CYC consecutive cycles with no write.
- R4: While protect_on is 0, every write is forwarded, except the last write of the enable sequence.
- R5: The writes AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, 20h@5555h clear protect_on.
- R6: The same six writes with 10h as the last byte produce a single-cycle erase_start pulse.
- R7: id_mode is set by a short entry (prefix, then 90h@5555h) or by a long entry (the six-write form ending in 60h@5555h). It is cleared by the prefix followed by F0h@5555h.
- R8: rd_en in identification mode gives, one cycle later, rd_id_valid=1 with rd_id_data DAh for address 0000h, C8h for 0001h, and 00h for any other address. Outside identification mode, rd_id_valid is 0.
- R9: rst clears id_mode, the matcher and the window. It does not change protect_on, which is 1 from power-up.
- R10: A write that does not continue a sequence returns the matcher to idle. If that write is AAh@5555h, it counts as the first step of a new sequence.
- R11: Every effect of a write shows on the outputs in the cycle after the clock edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | A bus write is present this cycle |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data byte |
| rd_en | input | 1 | A bus read is present this cycle |
| rd_addr | input | ADDR_W | Read address |
| pl_write_ok | output | 1 | Previous cycle's write goes to the page loader |
| pl_addr | output | ADDR_W | Address of the forwarded write |
| pl_data | output | 8 | Data of the forwarded write |
| erase_start | output | 1 | One-cycle chip-erase request |
| id_mode | output | 1 | Identification read mode active |
| protect_on | output | 1 | Software write protection set |
| rd_id_valid | output | 1 | The read answered with an identification byte |
| rd_id_data | output | 8 | Identification byte |

## Verification
The assertions check, on every cycle, that each change of protect_on, id_mode or erase_start comes right after a write whose data byte can trigger it. They also check that a forwarded write carries the sampled address and data, that an unprotected write is always forwarded, and that identification reads at address 0 give the manufacturer code. Some behaviour only the bench scenarios can show: the full ordering of each six-write sequence, the restart on a broken prefix, the exact cycle at which the window closes, and the fact that protection survives reset.

// File: rtl/ulk_pkg.sv
package ulk_pkg;
  localparam int BYTE_W = 8;

  localparam logic [15:0] ADR_FIRST  = 16'h5555;
  localparam logic [15:0] ADR_SECOND = 16'h2AAA;

  localparam logic [BYTE_W-1:0] KEY_ONE    = 8'hAA;
  localparam logic [BYTE_W-1:0] KEY_TWO    = 8'h55;
  localparam logic [BYTE_W-1:0] OP_LOCK    = 8'hA0;
  localparam logic [BYTE_W-1:0] OP_EXTEND  = 8'h80;
  localparam logic [BYTE_W-1:0] OP_ID_SHRT = 8'h90;
  localparam logic [BYTE_W-1:0] OP_ID_QUIT = 8'hF0;
  localparam logic [BYTE_W-1:0] OP_UNLOCK  = 8'h20;
  localparam logic [BYTE_W-1:0] OP_ERASE   = 8'h10;
  localparam logic [BYTE_W-1:0] OP_ID_LONG = 8'h60;

  localparam logic [BYTE_W-1:0] CODE_MAKER  = 8'hDA;
  localparam logic [BYTE_W-1:0] CODE_DEVICE = 8'hC8;

  // matcher position: A* = inside first prefix, B* = after the extend byte
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_A1   = 3'd1,
    ST_A2   = 3'd2,
    ST_B0   = 3'd3,
    ST_B1   = 3'd4,
    ST_B2   = 3'd5
  } seq_st_t;

  typedef struct packed {
    logic lock;
    logic unlock;
    logic erase;
    logic id_on;
    logic id_off;
  } ulk_ev_t;
endpackage

// File: rtl/ulk_step_matcher.sv
module ulk_step_matcher
  import ulk_pkg::*;
#(
  parameter int CMP_W = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic [CMP_W-1:0]  wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  output ulk_ev_t           ev
);
  localparam logic [CMP_W-1:0] ADR_A = CMP_W'(ADR_FIRST);
  localparam logic [CMP_W-1:0] ADR_B = CMP_W'(ADR_SECOND);

  seq_st_t st_q, st_n;
  logic    hit_a, hit_b, key1, key2;
  seq_st_t restart;
  ulk_ev_t ev_raw;

  assign hit_a   = (wr_addr == ADR_A);
  assign hit_b   = (wr_addr == ADR_B);
  assign key1    = hit_a && (wr_data == KEY_ONE);
  assign key2    = hit_b && (wr_data == KEY_TWO);
  // a breaking write may itself open a new sequence
  assign restart = key1 ? ST_A1 : ST_IDLE;

  always_comb begin
    st_n   = st_q;
    ev_raw = '0;
    if (wr_valid) begin
      unique case (st_q)
        ST_IDLE: st_n = key1 ? ST_A1 : ST_IDLE;
        ST_A1:   st_n = key2 ? ST_A2 : restart;
        ST_A2: begin
          st_n = ST_IDLE;
          if (hit_a && wr_data == OP_LOCK)         ev_raw.lock   = 1'b1;
          else if (hit_a && wr_data == OP_ID_SHRT) ev_raw.id_on  = 1'b1;
          else if (hit_a && wr_data == OP_ID_QUIT) ev_raw.id_off = 1'b1;
          else if (hit_a && wr_data == OP_EXTEND)  st_n = ST_B0;
          else                                     st_n = restart;
        end
        ST_B0:   st_n = key1 ? ST_B1 : ST_IDLE;
        ST_B1:   st_n = key2 ? ST_B2 : restart;
        ST_B2: begin
          st_n = ST_IDLE;
          if (hit_a && wr_data == OP_UNLOCK)       ev_raw.unlock = 1'b1;
          else if (hit_a && wr_data == OP_ERASE)   ev_raw.erase  = 1'b1;
          else if (hit_a && wr_data == OP_ID_LONG) ev_raw.id_on  = 1'b1;
          else                                     st_n = restart;
        end
        default: st_n = ST_IDLE;
      endcase
    end
  end

  assign ev = rst ? '0 : ev_raw;

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_IDLE;
    else     st_q <= st_n;
  end
endmodule

// File: rtl/ulk_load_window.sv
module ulk_load_window #(
  parameter int WINDOW_CYC = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic open_req,
  input  logic write_seen,
  output logic win_open
);
  localparam int CW = $clog2(WINDOW_CYC + 1);
  localparam logic [CW-1:0] LAST_IDLE = CW'(WINDOW_CYC - 1);

  logic [CW-1:0] idle_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      win_open <= 1'b0;
      idle_q   <= '0;
    end else if (open_req) begin
      win_open <= 1'b1;
      idle_q   <= '0;
    end else if (win_open) begin
      if (write_seen) begin
        idle_q <= '0;
      end else if (idle_q == LAST_IDLE) begin
        win_open <= 1'b0;
        idle_q   <= '0;
      end else begin
        idle_q <= idle_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ulk_id_rom.sv
module ulk_id_rom
  import ulk_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              id_mode,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_hit,
  output logic [BYTE_W-1:0] rd_byte
);
  localparam int N_ID = 2;

  logic [BYTE_W-1:0] code_tab [N_ID];
  logic              in_tab;
  logic              take;

  for (genvar g = 0; g < N_ID; g++) begin : g_code
    assign code_tab[g] = (g == 0) ? CODE_MAKER : CODE_DEVICE;
  end

  assign in_tab = (rd_addr < ADDR_W'(N_ID));
  assign take   = rd_en && id_mode;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_hit  <= 1'b0;
      rd_byte <= '0;
    end else begin
      rd_hit  <= take;
      rd_byte <= (take && in_tab) ? code_tab[rd_addr[0]] : '0;
    end
  end
endmodule

// File: rtl/unlock_seq_decoder.sv
module unlock_seq_decoder
  import ulk_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int CMP_W      = 15,
  parameter int WINDOW_CYC = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              pl_write_ok,
  output logic [ADDR_W-1:0] pl_addr,
  output logic [BYTE_W-1:0] pl_data,
  output logic              erase_start,
  output logic              id_mode,
  output logic              protect_on,
  output logic              rd_id_valid,
  output logic [BYTE_W-1:0] rd_id_data
);
  ulk_ev_t ev;
  logic    win_open;
  logic    prot_q = 1'b1;  // power-up value; reset does not touch it

  ulk_step_matcher #(.CMP_W(CMP_W)) u_match (
    .clk      (clk),
    .rst      (rst),
    .wr_valid (wr_valid),
    .wr_addr  (wr_addr[CMP_W-1:0]),
    .wr_data  (wr_data),
    .ev       (ev)
  );

  ulk_load_window #(.WINDOW_CYC(WINDOW_CYC)) u_win (
    .clk        (clk),
    .rst        (rst),
    .open_req   (ev.lock),
    .write_seen (wr_valid),
    .win_open   (win_open)
  );

  ulk_id_rom #(.ADDR_W(ADDR_W)) u_rom (
    .clk     (clk),
    .rst     (rst),
    .id_mode (id_mode),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .rd_hit  (rd_id_valid),
    .rd_byte (rd_id_data)
  );

  always_ff @(posedge clk) begin
    if (ev.unlock)    prot_q <= 1'b0;
    else if (ev.lock) prot_q <= 1'b1;
  end
  assign protect_on = prot_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pl_write_ok <= 1'b0;
      erase_start <= 1'b0;
      id_mode     <= 1'b0;
    end else begin
      pl_write_ok <= wr_valid && !ev.lock && (!prot_q || win_open);
      erase_start <= ev.erase;
      if (ev.id_off)     id_mode <= 1'b0;
      else if (ev.id_on) id_mode <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_valid) begin
      pl_addr <= wr_addr;
      pl_data <= wr_data;
    end
  end
endmodule

// File: rtl/unlock_seq_decoder_chk.sv
module unlock_seq_decoder_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_valid,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [7:0]        wr_data,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              pl_write_ok,
  input logic [ADDR_W-1:0] pl_addr,
  input logic [7:0]        pl_data,
  input logic              erase_start,
  input logic              id_mode,
  input logic              protect_on,
  input logic              rd_id_valid,
  input logic [7:0]        rd_id_data
);
  p_fwd_cause_r3: assert property (@(posedge clk) disable iff (rst)
    pl_write_ok |-> $past(wr_valid));

  p_fwd_payload_r3: assert property (@(posedge clk) disable iff (rst)
    pl_write_ok |-> (pl_addr == $past(wr_addr) && pl_data == $past(wr_data)));

  p_unprot_forward_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !protect_on && wr_data != 8'hA0) |=> pl_write_ok);

  p_lock_cause_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(protect_on) |-> $past(wr_valid && wr_data == 8'hA0 && wr_addr[14:0] == 15'h5555));

  p_unlock_cause_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(protect_on) |-> $past(wr_valid && wr_data == 8'h20 && wr_addr[14:0] == 15'h5555));

  p_erase_single_r6: assert property (@(posedge clk) disable iff (rst)
    erase_start |=> !erase_start);

  p_erase_cause_r6: assert property (@(posedge clk) disable iff (rst)
    erase_start |-> $past(wr_valid && wr_data == 8'h10 && wr_addr[14:0] == 15'h5555));

  p_id_entry_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(id_mode) |-> $past(wr_valid && (wr_data == 8'h90 || wr_data == 8'h60)));

  p_id_exit_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(id_mode) |-> ($past(rst) || $past(wr_valid && wr_data == 8'hF0)));

  p_id_valid_r8: assert property (@(posedge clk) disable iff (rst)
    rd_id_valid |-> $past(rd_en && id_mode));

  p_id_maker_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_id_valid && $past(rd_addr) == '0) |-> rd_id_data == 8'hDA);
endmodule

bind unlock_seq_decoder unlock_seq_decoder_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/unlock_seq_decoder_tb.sv
module unlock_seq_decoder_tb;
  localparam int WIN = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_valid = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        rd_en = 1'b0;
  logic [15:0] rd_addr = '0;
  logic        pl_write_ok, erase_start, id_mode, protect_on, rd_id_valid;
  logic [15:0] pl_addr;
  logic [7:0]  pl_data, rd_id_data;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  unlock_seq_decoder #(.ADDR_W(16), .CMP_W(15), .WINDOW_CYC(WIN)) u_dut (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .pl_write_ok(pl_write_ok), .pl_addr(pl_addr),
    .pl_data(pl_data), .erase_start(erase_start), .id_mode(id_mode),
    .protect_on(protect_on), .rd_id_valid(rd_id_valid), .rd_id_data(rd_id_data)
  );

  typedef struct packed {
    logic [15:0] a;
    logic [7:0]  d;
    logic        p;
    logic        id;
    logic        er;
    logic        g;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 46;
  localparam vec_t VEC [NV] = '{
    '{16'h0100, 8'h11, 1'b1, 1'b0, 1'b0, 1'b0, 4'd3},  // R3 protected, no window
    '{16'h5555, 8'hAA, 1'b1, 1'b0, 1'b0, 1'b0, 4'd2},  // R2 enable sequence
    '{16'h2AAA, 8'h55, 1'b1, 1'b0, 1'b0, 1'b0, 4'd2},
    '{16'h5555, 8'hA0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd2},
    '{16'h0100, 8'h12, 1'b1, 1'b0, 1'b0, 1'b1, 4'd3},  // R3 inside window
    '{16'h017F, 8'h34, 1'b1, 1'b0, 1'b0, 1'b1, 4'd3},
    '{16'h5555, 8'hAA, 1'b1, 1'b0, 1'b0, 1'b1, 4'd5},  // R5 disable
    '{16'h2AAA, 8'h55, 1'b1, 1'b0, 1'b0, 1'b1, 4'd5},
    '{16'h5555, 8'h80, 1'b1, 1'b0, 1'b0, 1'b1, 4'd5},
    '{16'h5555, 8'hAA, 1'b1, 1'b0, 1'b0, 1'b1, 4'd5},
    '{16'h2AAA, 8'h55, 1'b1, 1'b0, 1'b0, 1'b1, 4'd5},
    '{16'h5555, 8'h20, 1'b0, 1'b0, 1'b0, 1'b1, 4'd5},
    '{16'h0200, 8'h77, 1'b0, 1'b0, 1'b0, 1'b1, 4'd4},  // R4 unprotected
    '{16'h5555, 8'hAA, 1'b0, 1'b0, 1'b0, 1'b1, 4'd6},  // R6 erase
    '{16'h2AAA, 8'h55, 1'b0, 1'b0, 1'b0, 1'b1, 4'd6},
    '{16'h5555, 8'h80, 1'b0, 1'b0, 1'b0, 1'b1, 4'd6},
    '{16'h5555, 8'hAA, 1'b0, 1'b0, 1'b0, 1'b1, 4'd6},
    '{16'h2AAA, 8'h55, 1'b0, 1'b0, 1'b0, 1'b1, 4'd6},
    '{16'h5555, 8'h10, 1'b0, 1'b0, 1'b1, 1'b1, 4'd6},
    '{16'h0300, 8'h10, 1'b0, 1'b0, 1'b0, 1'b1, 4'd6},  // R6 pulse ends
    '{16'hD555, 8'hAA, 1'b0, 1'b0, 1'b0, 1'b1, 4'd1},  // R1 bit 15 set
    '{16'hAAAA, 8'h55, 1'b0, 1'b0, 1'b0, 1'b1, 4'd1},
    '{16'hD555, 8'h90, 1'b0, 1'b1, 1'b0, 1'b1, 4'd1},  // R1 + R7 short entry
    '{16'h5555, 8'hAA, 1'b0, 1'b1, 1'b0, 1'b1, 4'd7},  // R7 exit
    '{16'h2AAA, 8'h55, 1'b0, 1'b1, 1'b0, 1'b1, 4'd7},
    '{16'h5555, 8'hF0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd7},
    '{16'h5555, 8'hAA, 1'b0, 1'b0, 1'b0, 1'b1, 4'd7},  // R7 long entry
    '{16'h2AAA, 8'h55, 1'b0, 1'b0, 1'b0, 1'b1, 4'd7},
    '{16'h5555, 8'h80, 1'b0, 1'b0, 1'b0, 1'b1, 4'd7},
    '{16'h5555, 8'hAA, 1'b0, 1'b0, 1'b0, 1'b1, 4'd7},
    '{16'h2AAA, 8'h55, 1'b0, 1'b0, 1'b0, 1'b1, 4'd7},
    '{16'h5555, 8'h60, 1'b0, 1'b1, 1'b0, 1'b1, 4'd7},
    '{16'h5555, 8'hAA, 1'b0, 1'b1, 1'b0, 1'b1, 4'd10}, // R10 repeat key restarts
    '{16'h5555, 8'hAA, 1'b0, 1'b1, 1'b0, 1'b1, 4'd10},
    '{16'h2AAA, 8'h55, 1'b0, 1'b1, 1'b0, 1'b1, 4'd10},
    '{16'h5555, 8'hF0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd10},
    '{16'h5555, 8'hAA, 1'b0, 1'b0, 1'b0, 1'b1, 4'd10}, // R10 break in third step
    '{16'h2AAA, 8'h55, 1'b0, 1'b0, 1'b0, 1'b1, 4'd10},
    '{16'h5555, 8'hAA, 1'b0, 1'b0, 1'b0, 1'b1, 4'd10},
    '{16'h2AAA, 8'h55, 1'b0, 1'b0, 1'b0, 1'b1, 4'd10},
    '{16'h5555, 8'hA0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd10}, // R2 finisher not forwarded
    '{16'h5555, 8'hAA, 1'b1, 1'b0, 1'b0, 1'b1, 4'd10}, // R10 break to idle
    '{16'h2AAA, 8'h55, 1'b1, 1'b0, 1'b0, 1'b1, 4'd10},
    '{16'h5555, 8'h33, 1'b1, 1'b0, 1'b0, 1'b1, 4'd10},
    '{16'h2AAA, 8'h55, 1'b1, 1'b0, 1'b0, 1'b1, 4'd10},
    '{16'h5555, 8'h90, 1'b1, 1'b0, 1'b0, 1'b1, 4'd10}
  };

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // called at a falling edge; write sampled at the next rising edge
  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a);
    rd_en = 1'b1; rd_addr = a;
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_reset();
    rst = 1'b1;
    idle(2);
    rst = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R9: state after reset, protection set from power-up
    chk(protect_on == 1'b1, "R9 protect after reset", 32'(protect_on), 1);
    chk(id_mode == 1'b0, "R9 id after reset", 32'(id_mode), 0);
    chk(erase_start == 1'b0, "R9 erase after reset", 32'(erase_start), 0);
    chk(pl_write_ok == 1'b0, "R9 gate after reset", 32'(pl_write_ok), 0);
    chk(rd_id_valid == 1'b0, "R9 rd after reset", 32'(rd_id_valid), 0);

    // vector walk; each entry's effect is checked one edge later (R11)
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i].a, VEC[i].d);
      chk(protect_on == VEC[i].p, $sformatf("vec%0d R%0d protect", i, VEC[i].req),
          32'(protect_on), 32'(VEC[i].p));
      chk(id_mode == VEC[i].id, $sformatf("vec%0d R%0d id", i, VEC[i].req),
          32'(id_mode), 32'(VEC[i].id));
      chk(erase_start == VEC[i].er, $sformatf("vec%0d R%0d erase", i, VEC[i].req),
          32'(erase_start), 32'(VEC[i].er));
      chk(pl_write_ok == VEC[i].g, $sformatf("vec%0d R%0d gate", i, VEC[i].req),
          32'(pl_write_ok), 32'(VEC[i].g));
      if (VEC[i].g)
        chk(pl_addr == VEC[i].a && pl_data == VEC[i].d,
            $sformatf("vec%0d R%0d payload", i, VEC[i].req),
            {pl_addr, pl_data, 8'h0}, {VEC[i].a, VEC[i].d, 8'h0});
    end

    // R3: window open after WIN-1 idle cycles, closed after WIN idle cycles
    idle(WIN - 1);
    wr(16'h0400, 8'h5A);
    chk(pl_write_ok == 1'b1, "R3 window edge open", 32'(pl_write_ok), 1);
    idle(WIN);
    wr(16'h0401, 8'h5B);
    chk(pl_write_ok == 1'b0, "R3 window closed", 32'(pl_write_ok), 0);

    // R9: reset clears id mode but keeps protection
    wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(16'h5555, 8'h80);
    wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(16'h5555, 8'h60);
    chk(id_mode == 1'b1, "R7 long entry while protected", 32'(id_mode), 1);
    pulse_reset();
    chk(id_mode == 1'b0, "R9 id cleared by reset", 32'(id_mode), 0);
    chk(protect_on == 1'b1, "R9 protect kept over reset", 32'(protect_on), 1);
    // R9: matcher cleared by reset
    wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55);
    pulse_reset();
    wr(16'h5555, 8'h90);
    chk(id_mode == 1'b0, "R9 matcher cleared by reset", 32'(id_mode), 0);
    wr(16'h0500, 8'h01);
    chk(pl_write_ok == 1'b0, "R9 window cleared by reset", 32'(pl_write_ok), 0);

    // R8: identification reads
    rd(16'h0000);
    chk(rd_id_valid == 1'b0, "R8 read outside id mode", 32'(rd_id_valid), 0);
    wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(16'h5555, 8'h90);
    rd(16'h0000);
    chk(rd_id_valid && rd_id_data == 8'hDA, "R8 maker code", {rd_id_valid, rd_id_data}, {1'b1, 8'hDA});
    rd(16'h0001);
    chk(rd_id_valid && rd_id_data == 8'hC8, "R8 device code", {rd_id_valid, rd_id_data}, {1'b1, 8'hC8});
    rd(16'h0005);
    chk(rd_id_valid && rd_id_data == 8'h00, "R8 other address", {rd_id_valid, rd_id_data}, {1'b1, 8'h00});
    wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(16'h5555, 8'hF0);
    rd(16'h0001);
    chk(rd_id_valid == 1'b0, "R8 read after exit", 32'(rd_id_valid), 0);

    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end
endmodule